// File: doc/BRIEF.md
# Tagged Translation Cache with Tree Pseudo-LRU Replacement

This block is a small fully associative cache of page translations for a 32-bit virtual address split into a page number and a 12-bit offset inside a 4 KB page. Each of its eight entries holds a virtual page number, the address-space tag of the process that owns it, a physical frame number and a set of permission bits. A lookup compares the page number and the current process tag against every valid entry. On a hit it returns the physical address and the permissions in the same cycle. On a miss it raises a miss flag, and an external table walker is expected to answer with a refill.

Several address spaces can live in the cache together, because every entry is tagged. When tagging is switched off, the tag comparison is skipped. Software must then empty the cache on every context switch, and the block gives it a one-cycle flush of all entries for that. A second flush removes only the entries that carry a chosen tag. A refill goes into a free entry when there is one. Only when every entry is valid does it displace the entry chosen by a binary-tree pseudo-LRU. Each hit and each refill steers the tree bits along that entry's path toward the opposite subtree.

Stream rules: a lookup has no back-pressure. It is accepted in any cycle where `lk_valid` is high, and its result is combinational in that cycle. A refill is a valid/ready transfer that completes on a clock edge where both `fill_valid` and `fill_ready` are high. `fill_ready` is low in any cycle where a flush is requested. The walker must then hold `fill_valid` and the refill fields steady until the transfer completes.

Top module: `tlb_tagged`

## Requirements
- R1: After reset no entry is valid, so every lookup misses. `lk_hit` and `lk_miss` are never high together, and both are low while `lk_valid` is low.
- R2: A hitting lookup returns, in the same cycle, `lk_paddr` = {stored frame number, `lk_vaddr[11:0]`} and the stored permission bits.
- R3: With `tag_en` high, a hit also requires the entry's stored tag to equal `cur_asid`. With `tag_en` low, the tag is ignored and only the page number is compared.
- R4: An accepted refill of a page not already present goes into the lowest-numbered invalid entry. An existing entry is displaced only when all entries are valid.
- R5: `flush_all` invalidates every entry at the next clock edge.
- R6: `flush_tag_en` invalidates, at the next clock edge, exactly the entries whose stored tag equals `flush_tag`. Other entries stay valid.
- R7: `fill_ready` is high except in a cycle where `flush_all` or `flush_tag_en` is high. A refill offered in such a cycle is not written.
- R8: A lookup and a refill of the same absent page in the same cycle produce a miss. The page hits from the next cycle on.
- R9: A refill whose page number matches a valid entry overwrites that entry in place. The tag must also match when `tag_en` is high. No other entry is displaced.
- R10: Replacement state is 7 node bits in heap order: node 0 is the root, and the children of node k are 2k+1 and 2k+2. All bits are 0 after reset. The victim is found by walking from the root, where bit 0 means go left (lower entry numbers) and bit 1 means go right. Every hit and every accepted refill sets each node on that entry's path to point at the other subtree. When a hit and a refill occur in the same cycle, the refill's update is applied last. As a result, the entry just accessed is never the next victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_asid | input | 8 | Tag of the running process, used for lookup and refill |
| tag_en | input | 1 | 1: compare tags; 0: ignore tags |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup missed |
| lk_paddr | output | 32 | Translated physical address (valid on hit) |
| lk_perm | output | 4 | Permission bits of the hitting entry |
| fill_valid | input | 1 | Refill offered by the walker |
| fill_ready | output | 1 | Refill can be accepted this cycle |
| fill_vpn | input | 20 | Page number being refilled |
| fill_pfn | input | 20 | Frame number for that page |
| fill_perm | input | 4 | Permission bits for that page |
| flush_all | input | 1 | Invalidate all entries |
| flush_tag_en | input | 1 | Invalidate the entries whose tag matches `flush_tag` |
| flush_tag | input | 8 | Tag selected for the per-process flush |

## Verification
A corrupted tree bit does not show at once. It becomes visible on the next refill into a full cache, which displaces the wrong page. The lookup of the page that should have survived then misses one cycle later. A bad valid bit or a misplaced refill shows as a wrong hit or a wrong miss on the very next lookup of the affected page. The bench therefore follows every refill with lookups of the page that should have been displaced and of pages that should have stayed. This ties each replacement decision to a port-visible result within two cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Where an accepted refill is written.
  typedef enum logic [1:0] {
    FILL_SAME  = 2'd0,   // page already present: overwrite in place
    FILL_FREE  = 2'd1,   // lowest invalid entry
    FILL_EVICT = 2'd2    // pseudo-LRU victim
  } fill_src_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ASID_W-1:0]  cur_asid,
  input  logic               tag_en,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] lk_match,
  output logic [PFN_W-1:0]   lk_pfn,
  output logic [PERM_W-1:0]  lk_perm,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic [PERM_W-1:0]  fill_perm,
  input  logic               fill_we,
  input  logic [IDX_W-1:0]   fill_idx,
  output logic [ENTRIES-1:0] fill_match,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               flush_all,
  input  logic               flush_tag_en,
  input  logic [ASID_W-1:0]  flush_tag
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];

  assign valid_vec = valid_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic tag_ok;
    logic kill;
    logic wr;

    assign tag_ok        = !tag_en || (asid_q[i] == cur_asid);
    assign lk_match[i]   = valid_q[i] && tag_ok && (vpn_q[i] == lk_vpn);
    assign fill_match[i] = valid_q[i] && tag_ok && (vpn_q[i] == fill_vpn);
    assign kill          = flush_all || (flush_tag_en && (asid_q[i] == flush_tag));
    assign wr            = fill_we && (fill_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
      end else if (kill) begin
        valid_q[i] <= 1'b0;
      end else if (wr) begin
        valid_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr && !kill) begin
        vpn_q[i]  <= fill_vpn;
        asid_q[i] <= cur_asid;
        pfn_q[i]  <= fill_pfn;
        perm_q[i] <= fill_perm;
      end
    end

    AST_TAG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_tag_en && (asid_q[i] == flush_tag)) |=> !valid_q[i]); // R6
  end

  // Read port: the match vector is one-hot on a legal state, so an OR of
  // the gated payloads is the selected entry.
  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_pfn  = lk_pfn  | pfn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
    end
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0)); // R5
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tag_en |-> $onehot0(lk_match)); // R9

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int NODES  = ENTRIES - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,     // hit access
  input  logic [IDX_W-1:0] a_leaf,
  input  logic             b_en,     // refill access, applied last
  input  logic [IDX_W-1:0] b_leaf,
  output logic [IDX_W-1:0] victim
);

  logic [NODES-1:0] tree_q, tree_d;

  // Point every node on the leaf's path at the sibling subtree.
  function automatic logic [NODES-1:0] steer_away(input logic [NODES-1:0] t,
                                                  input logic [IDX_W-1:0] leaf);
    logic [NODES-1:0] r;
    r = t;
    for (int k = 0; k < IDX_W; k++) begin
      int node;
      node = (2 ** k) - 1 + int'(leaf >> (IDX_W - k));
      r[node] = ~leaf[IDX_W-1-k];
    end
    return r;
  endfunction

  always_comb begin
    tree_d = tree_q;
    if (a_en) tree_d = steer_away(tree_d, a_leaf);
    if (b_en) tree_d = steer_away(tree_d, b_leaf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tree_q <= '0;
    else        tree_q <= tree_d;
  end

  // Walk from the root: 0 goes left, 1 goes right.
  always_comb begin
    int node;
    node   = 0;
    victim = '0;
    for (int k = 0; k < IDX_W; k++) begin
      victim[IDX_W-1-k] = tree_q[node];
      node = 2 * node + 1 + int'(tree_q[node]);
    end
  end

  AST_VICTIM_NOT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    b_en |=> (victim != $past(b_leaf))); // R10
  AST_VICTIM_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !b_en) |=> (victim != $past(a_leaf))); // R10

endmodule

// File: rtl/tlb_fill_sel.sv
module tlb_fill_sel
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] fill_match,
  output fill_src_e          src,
  output logic [IDX_W-1:0]   same_idx,
  output logic [IDX_W-1:0]   free_idx
);

  logic any_free;

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_match[i]) same_idx = IDX_W'(i);
    end
  end

  // Lowest-numbered invalid entry wins: scan downward so it is written last.
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (|fill_match)   src = FILL_SAME;
    else if (any_free) src = FILL_FREE;
    else               src = FILL_EVICT;
  end

endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
  import tlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int PERM_W    = 4,
  parameter int ASID_W    = 8,
  parameter int ENTRIES   = 8,
  localparam int VPN_W    = ADDR_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              tag_en,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush_all,
  input  logic              flush_tag_en,
  input  logic [ASID_W-1:0] flush_tag
);

  logic [ENTRIES-1:0] lk_match, fill_match, valid_vec;
  logic [PFN_W-1:0]   hit_pfn;
  logic [IDX_W-1:0]   hit_idx, fill_idx, same_idx, free_idx, victim;
  logic               fill_we;
  fill_src_e          fill_src;

  assign fill_ready = !(flush_all || flush_tag_en);
  assign fill_we    = fill_valid && fill_ready;

  tlb_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
    .PFN_W(PFN_W), .PERM_W(PERM_W)
  ) u_cam (
    .clk(clk), .rst_n(rst_n),
    .cur_asid(cur_asid), .tag_en(tag_en),
    .lk_vpn(lk_vaddr[ADDR_W-1:PAGE_BITS]),
    .lk_match(lk_match), .lk_pfn(hit_pfn), .lk_perm(lk_perm),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_match(fill_match),
    .valid_vec(valid_vec),
    .flush_all(flush_all), .flush_tag_en(flush_tag_en), .flush_tag(flush_tag)
  );

  assign lk_hit   = lk_valid && (|lk_match);
  assign lk_miss  = lk_valid && !(|lk_match);
  assign lk_paddr = {hit_pfn, lk_vaddr[PAGE_BITS-1:0]};

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) hit_idx = IDX_W'(i);
    end
  end

  tlb_fill_sel #(.ENTRIES(ENTRIES)) u_sel (
    .valid_vec(valid_vec), .fill_match(fill_match),
    .src(fill_src), .same_idx(same_idx), .free_idx(free_idx)
  );

  always_comb begin
    case (fill_src)
      FILL_SAME: fill_idx = same_idx;
      FILL_FREE: fill_idx = free_idx;
      default:   fill_idx = victim;
    endcase
  end

  tlb_plru #(.ENTRIES(ENTRIES)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .a_en(lk_hit), .a_leaf(hit_idx),
    .b_en(fill_we), .b_leaf(fill_idx),
    .victim(victim)
  );

  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss)); // R1
  AST_NO_FILL_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_tag_en) |-> !fill_ready); // R7
  AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && fill_src == FILL_EVICT) |-> (&valid_vec)); // R4

endmodule

// File: tb/tlb_tagged_bench.sv
module tlb_tagged_bench;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cur_asid;
  logic        tag_en;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss, fill_ready;
  logic [31:0] lk_paddr;
  logic [3:0]  lk_perm;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [3:0]  fill_perm = '0;
  logic        flush_all = 1'b0;
  logic        flush_tag_en = 1'b0;
  logic [7:0]  flush_tag = '0;

  always #5 clk = ~clk;

  bit tag_on = 1'b1;
  int asid_cur = 1;
  assign tag_en   = tag_on;
  assign cur_asid = asid_cur[7:0];

  tlb_tagged u_tlb_tagged (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .tag_en(tag_en),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_paddr(lk_paddr), .lk_perm(lk_perm),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .flush_all(flush_all), .flush_tag_en(flush_tag_en), .flush_tag(flush_tag)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference state built from the requirements.
  bit m_v[N];
  int m_vpn[N], m_as[N], m_pfn[N], m_pm[N];
  bit m_t[N-1];

  function automatic int pfn_of(int vpn);  return (vpn * 5 + 3) & 'hFFFFF; endfunction
  function automatic int perm_of(int vpn); return vpn & 15; endfunction

  function automatic void m_touch(int l);
    for (int k = 0; k < 3; k++) begin
      int node = (1 << k) - 1 + (l >> (3 - k));
      int dir  = (l >> (2 - k)) & 1;
      m_t[node] = (dir == 0);
    end
  endfunction

  function automatic int m_victim();
    int node = 0;
    int l = 0;
    for (int k = 0; k < 3; k++) begin
      int b = int'(m_t[node]);
      l = l * 2 + b;
      node = 2 * node + 1 + b;
    end
    return l;
  endfunction

  function automatic int m_find(int vpn);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && (!tag_on || m_as[i] == asid_cur)) return i;
    return -1;
  endfunction

  function automatic void m_fill(int vpn, int pfn, int pm);
    int idx = m_find(vpn);
    if (idx < 0)
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
    if (idx < 0) idx = m_victim();
    m_v[idx] = 1'b1; m_vpn[idx] = vpn; m_as[idx] = asid_cur;
    m_pfn[idx] = pfn; m_pm[idx] = pm;
    m_touch(idx);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_lookup(input int vpn, input int off, input string req);
    int idx = m_find(vpn);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = 32'((vpn << 12) | (off & 'hFFF));
    #1;
    chk(lk_hit == (idx >= 0) && lk_miss == (idx < 0), req, "hit", lk_hit, idx >= 0);
    if (idx >= 0) begin
      chk(lk_paddr == 32'((m_pfn[idx] << 12) | (off & 'hFFF)), req, "paddr",
          lk_paddr, (m_pfn[idx] << 12) | (off & 'hFFF));
      chk(lk_perm == 4'(m_pm[idx]), req, "perm", lk_perm, m_pm[idx]);
      m_touch(idx);
    end
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic do_fill(input int vpn, input int pfn, input string req);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'(vpn); fill_pfn = 20'(pfn); fill_perm = 4'(perm_of(vpn));
    #1;
    chk(fill_ready == 1'b1, req, "fill_ready idle (R7)", fill_ready, 1);
    m_fill(vpn, pfn, perm_of(vpn));
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic check_resident(input string req);
    int vs[N];
    for (int i = 0; i < N; i++) vs[i] = m_v[i] ? m_vpn[i] : -1;
    for (int i = 0; i < N; i++) if (vs[i] >= 0) do_lookup(vs[i], i * 'h37, req);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int saved[N];
    int ev;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    for (int i = 0; i < N - 1; i++) m_t[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset, flags quiet without a request
    @(negedge clk); #1;
    chk(!lk_hit && !lk_miss, "R1", "idle flags", {lk_hit, lk_miss}, 0);
    do_lookup('h100, 0, "R1");
    do_lookup('h000, 5, "R1");
    do_lookup('hFFFFF, 'hFFF, "R1");

    // R2/R4: fill into free entries, then translate with varied offsets
    for (int i = 0; i < N; i++) do_fill('h100 + i, pfn_of('h100 + i), "R4");
    for (int i = 0; i < N; i++) do_lookup('h100 + i, i * 'h111, "R2");

    // R3: tag comparison on and off
    @(negedge clk); asid_cur = 2;
    do_lookup('h103, 'h10, "R3");
    @(negedge clk); tag_on = 1'b0;
    do_lookup('h103, 'h20, "R3");
    @(negedge clk); tag_on = 1'b1; asid_cur = 1;

    // R10: eviction sweep over a full cache
    for (int n = 0; n < 24; n++) begin
      ev = m_vpn[m_victim()];
      do_fill('h200 + n, pfn_of('h200 + n), "R10");
      do_lookup(ev, n, "R10");
      do_lookup('h200 + n, n * 3, "R10");
      do_lookup(m_vpn[(n * 3) % N], n * 7, "R10");
    end

    // R9: refill of a present page rewrites it in place
    do_fill(m_vpn[2], 'hABCDE, "R9");
    check_resident("R9");

    // R8: same-cycle lookup and refill of an absent page
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 32'('h300 << 12);
    fill_valid = 1'b1; fill_vpn = 20'h300; fill_pfn = 20'(pfn_of('h300)); fill_perm = 4'(perm_of('h300));
    #1;
    chk(lk_miss && !lk_hit, "R8", "same-cycle miss", {lk_hit, lk_miss}, 1);
    m_fill('h300, pfn_of('h300), perm_of('h300));
    @(posedge clk); #1;
    lk_valid = 1'b0; fill_valid = 1'b0;
    do_lookup('h300, 'h44, "R8");

    // R6/R7: per-tag flush with a refill offered in the same cycle
    @(negedge clk); asid_cur = 5;
    for (int i = 0; i < 3; i++) do_fill('h400 + i, pfn_of('h400 + i), "R6");
    @(negedge clk); asid_cur = 1;
    flush_tag_en = 1'b1; flush_tag = 8'd5;
    fill_valid = 1'b1; fill_vpn = 20'h555; fill_pfn = 20'(pfn_of('h555)); fill_perm = 4'(perm_of('h555));
    #1;
    chk(fill_ready == 1'b0, "R7", "ready during flush", fill_ready, 0);
    @(posedge clk); #1;
    flush_tag_en = 1'b0;
    for (int i = 0; i < N; i++) if (m_as[i] == 5) m_v[i] = 1'b0;
    #1;
    chk(fill_ready == 1'b1, "R7", "ready after flush", fill_ready, 1);
    m_fill('h555, pfn_of('h555), perm_of('h555));
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(negedge clk); asid_cur = 5;
    for (int i = 0; i < 3; i++) do_lookup('h400 + i, i, "R6");
    @(negedge clk); asid_cur = 1;
    check_resident("R6");

    // R4: freed entries are reused before anything is displaced
    do_fill('h600, pfn_of('h600), "R4");
    do_fill('h601, pfn_of('h601), "R4");
    check_resident("R4");

    // R5: flush everything
    for (int i = 0; i < N; i++) saved[i] = m_vpn[i];
    @(negedge clk); flush_all = 1'b1;
    @(posedge clk); #1; flush_all = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    for (int i = 0; i < N; i++) do_lookup(saved[i], i, "R5");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule